// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a management host access to a space of 32 internal devices, each holding 32 registers of 16 bits, while occupying a single address on the management bus. At that address the host sees only two registers: a command/status register (index 0) and a data register (index 1). To move a value, the host loads the data register if it is writing, then writes a command word that names the device and register. After that it polls the command/status register until the busy flag drops. A read result then sits in the data register.

The host side is a plain single-access register port. It stands in for management frames that have already been decoded, and each access reports completion with a one-cycle acknowledge. The internal side is a request/acknowledge bus: the request is held until a one-cycle acknowledge arrives. That bus drives a modelled register space whose acknowledge latency is a parameter. A strap input selects the bridge address. When the strap is zero, the bridge steps aside and every host access goes straight to the device/register pair it names.

Top module: `regbridge_top`

## Requirements
- R1: After reset, reading host register 0 returns 0x0000 (busy, error and command fields clear) and reading host register 1 returns 0x0000.
- R2: With a nonzero strap, a host write to register 1 at the strap address is returned unchanged by a following read of register 1.
- R3: A command word with bits 15:10 equal to 6'b100110 (0x9800 plus fields) reads the internal register whose device is in bits 9:5 and whose register number is in bits 4:0. Once busy clears, host register 1 holds that value.
- R4: A command word with bits 15:10 equal to 6'b100101 (0x9400 plus fields) writes the current content of host register 1 into the named internal register.
- R5: Busy (bit 15 of a register 0 read) is set from the edge that accepts a command until the edge that sees the internal acknowledge. A register 0 read issued in the cycle right after the command returns bit 15 set, and busy clears within ACK_LAT+3 polls.
- R6: A command written while busy is set is ignored, leaving its target register untouched. It sets an error flag (bit 14 of a register 0 read) that stays set through later good commands and is cleared only by reset.
- R7: A command word whose bits 15:10 are neither 6'b100110 nor 6'b100101 is ignored. Busy stays clear, the error flag is unchanged, the named register is untouched, and the register 0 fields keep the previous command.
- R8: With strap zero, a host access to (device, register) is carried out directly on the internal register at that pair, host register semantics do not apply, and the host acknowledge comes when the internal access completes.
- R9: With a nonzero strap, host accesses to any other device address are ignored: reads return 0xFFFF and writes change nothing.
- R10: Bits 9:5 and 4:0 of a register 0 read hold the device and register of the last accepted command, and bits 13:10 read as zero.
- R11: The internal request stays asserted with a stable address until it is acknowledged, and no acknowledge occurs without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Bridge address on the management bus; zero selects direct mode |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_phy | input | 5 | Management-bus device address of the access |
| host_reg | input | 5 | Register index of the access |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle pulse when the access is complete |
| host_rdata | output | 16 | Read data, valid with host_ack |

## Verification
The main transfer path runs through a vector table of device/register/value triples. The table includes the extreme corners (device 0 register 0, device 31 register 31) and all-ones, single-bit and alternating values. All writes go first and all reads follow, so an address field swapped or dropped in the command decode shows up as a wrong value. The busy window is probed by polling right after a command, and the error path is probed by a second command issued inside that window. An undefined opcode that still carries bit 15 set is also tried, which separates a real opcode match from a test of bit 15 alone. Direct mode is checked against indirect reads of the same cells, including device 16 register 0, so a direct access that wrongly lands in the bridge registers is caught.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

    // Opcode field in the top bits of a command word
    localparam int OP_W = 6;
    localparam logic [OP_W-1:0] OP_READ  = 6'b100110;
    localparam logic [OP_W-1:0] OP_WRITE = 6'b100101;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INDIR  = 2'd1,
        ST_DIRECT = 2'd2
    } bridge_st_e;

endpackage

// File: rtl/regbridge_cmddec.sv
module regbridge_cmddec
    import regbridge_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cmd,
    output logic              is_rd,
    output logic              is_wr,
    output logic [ADDR_W-1:0] dev,
    output logic [ADDR_W-1:0] rg
);
    logic [OP_W-1:0] op;

    always_comb begin
        op    = cmd[DATA_W-1 -: OP_W];
        is_rd = (op == OP_READ);
        is_wr = (op == OP_WRITE);
        dev   = cmd[2*ADDR_W-1 -: ADDR_W];
        rg    = cmd[ADDR_W-1:0];
    end
endmodule

// File: rtl/regbridge_space.sv
module regbridge_space #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int ACK_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] dev,
    input  logic [ADDR_W-1:0] rg,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = $clog2(ACK_LAT) + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } space_s;

    space_s s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic              fire;

    always_comb begin
        idx  = {dev, rg};
        fire = req && !s_q.ack && (s_q.cnt == CNT_W'(ACK_LAT - 1));
        s_d     = s_q;
        s_d.ack = 1'b0;
        if (req && !s_q.ack) begin
            if (fire) begin
                s_d.cnt   = '0;
                s_d.ack   = 1'b1;
                s_d.rdata = we ? '0 : mem[idx];
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (fire && we) mem[idx] <= wdata;
    end

    assign ack   = s_q.ack;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/regbridge_ctrl.sv
module regbridge_ctrl
    import regbridge_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_phy,
    input  logic [ADDR_W-1:0] host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_dev,
    input  logic [ADDR_W-1:0] cmd_rg,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              int_req,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_dev,
    output logic [ADDR_W-1:0] int_reg,
    output logic [DATA_W-1:0] int_wdata,
    input  logic              int_ack,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              busy,
    output logic              err
);
    localparam int PAD_W = DATA_W - 2 - 2 * ADDR_W;

    typedef struct packed {
        bridge_st_e        st;
        logic              err;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] cdev;
        logic [ADDR_W-1:0] creg;
        logic              cwe;
        logic              hack;
        logic [DATA_W-1:0] hrdata;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  busy_q;
    logic  direct_mode;
    logic  addr_hit;

    always_comb begin
        busy_q      = (c_q.st == ST_INDIR);
        direct_mode = (strap_addr == '0);
        addr_hit    = (host_phy == strap_addr);

        c_d      = c_q;
        c_d.hack = 1'b0;

        // Completion of an internal transfer
        if (int_ack) begin
            if (c_q.st == ST_INDIR) begin
                c_d.st = ST_IDLE;
                if (!c_q.cwe) c_d.data = int_rdata;
            end else if (c_q.st == ST_DIRECT) begin
                c_d.st     = ST_IDLE;
                c_d.hack   = 1'b1;
                c_d.hrdata = c_q.cwe ? '0 : int_rdata;
            end
        end

        // Host access
        if (host_req) begin
            if (direct_mode) begin
                if (c_q.st == ST_IDLE) begin
                    c_d.st   = ST_DIRECT;
                    c_d.cdev = host_phy;
                    c_d.creg = host_reg;
                    c_d.cwe  = host_we;
                    if (host_we) c_d.data = host_wdata;
                end
            end else if (!addr_hit) begin
                c_d.hack   = 1'b1;
                c_d.hrdata = '1;
            end else begin
                c_d.hack   = 1'b1;
                c_d.hrdata = '0;
                if (host_reg == '0) begin
                    if (host_we) begin
                        if (busy_q) begin
                            c_d.err = 1'b1;
                        end else if (cmd_rd || cmd_wr) begin
                            c_d.st   = ST_INDIR;
                            c_d.cdev = cmd_dev;
                            c_d.creg = cmd_rg;
                            c_d.cwe  = cmd_wr;
                        end
                    end else begin
                        c_d.hrdata = {busy_q, c_q.err, {PAD_W{1'b0}},
                                      c_q.cdev, c_q.creg};
                    end
                end else if (host_reg == ADDR_W'(1)) begin
                    if (host_we) c_d.data   = host_wdata;
                    else         c_d.hrdata = c_q.data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign host_ack   = c_q.hack;
    assign host_rdata = c_q.hrdata;
    assign int_req    = (c_q.st != ST_IDLE);
    assign int_we     = c_q.cwe;
    assign int_dev    = c_q.cdev;
    assign int_reg    = c_q.creg;
    assign int_wdata  = c_q.data;
    assign busy       = busy_q;
    assign err        = c_q.err;
endmodule

// File: rtl/regbridge_top.sv
module regbridge_top #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int ACK_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_phy,
    input  logic [ADDR_W-1:0] host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata
);
    logic              cmd_rd_w, cmd_wr_w;
    logic [ADDR_W-1:0] cmd_dev_w, cmd_rg_w;
    logic              int_req_w, int_we_w, int_ack_w;
    logic [ADDR_W-1:0] int_dev_w, int_reg_w;
    logic [DATA_W-1:0] int_wdata_w, int_rdata_w;
    logic              busy_w, err_w;

    regbridge_cmddec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .cmd   (host_wdata),
        .is_rd (cmd_rd_w),
        .is_wr (cmd_wr_w),
        .dev   (cmd_dev_w),
        .rg    (cmd_rg_w)
    );

    regbridge_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_phy   (host_phy),
        .host_reg   (host_reg),
        .host_wdata (host_wdata),
        .cmd_rd     (cmd_rd_w),
        .cmd_wr     (cmd_wr_w),
        .cmd_dev    (cmd_dev_w),
        .cmd_rg     (cmd_rg_w),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .int_req    (int_req_w),
        .int_we     (int_we_w),
        .int_dev    (int_dev_w),
        .int_reg    (int_reg_w),
        .int_wdata  (int_wdata_w),
        .int_ack    (int_ack_w),
        .int_rdata  (int_rdata_w),
        .busy       (busy_w),
        .err        (err_w)
    );

    regbridge_space #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_LAT(ACK_LAT)) u_space (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (int_req_w),
        .we    (int_we_w),
        .dev   (int_dev_w),
        .rg    (int_reg_w),
        .wdata (int_wdata_w),
        .ack   (int_ack_w),
        .rdata (int_rdata_w)
    );
endmodule

// File: rtl/regbridge_chk.sv
module regbridge_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap,
    input logic              host_req,
    input logic              host_we,
    input logic              busy,
    input logic              err,
    input logic              int_req,
    input logic              int_ack,
    input logic [ADDR_W-1:0] int_dev
);
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !int_ack) |=> busy);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && int_ack) |=> !busy);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(host_req && host_we && busy));

    // R8
    direct_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap == '0 && !busy) |=> !busy);

    // R11
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> int_req);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (int_req && $stable(int_dev)));
endmodule

bind regbridge_top regbridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap_addr),
    .host_req (host_req),
    .host_we  (host_we),
    .busy     (busy_w),
    .err      (err_w),
    .int_req  (int_req_w),
    .int_ack  (int_ack_w),
    .int_dev  (int_dev_w)
);

// File: tb/regbridge_top_bench.sv
module regbridge_top_bench;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int ACK_LAT = 3;
    localparam logic [4:0] BR = 5'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = BR;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_phy = '0;
    logic [4:0]  host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    regbridge_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_LAT(ACK_LAT)) u_regbridge_top (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .host_req(host_req), .host_we(host_we), .host_phy(host_phy),
        .host_reg(host_reg), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata)
    );

    // {device, register, value}
    localparam logic [25:0] VEC [6] = '{
        {5'd0,  5'd0,  16'h0001},
        {5'd31, 5'd31, 16'hFFFF},
        {5'd1,  5'd2,  16'hA5A5},
        {5'd2,  5'd1,  16'h5A5A},
        {5'd16, 5'd0,  16'h8000},
        {5'd30, 5'd17, 16'h7FFE}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rd);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_phy = phy; host_reg = rg; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_ack && n < 50) begin
            @(negedge clk);
            n++;
        end
        rd = host_rdata;
    endtask

    task automatic poll(output int n, output logic [15:0] st);
        n = 0;
        do begin
            acc(1'b0, BR, 5'd0, 16'h0, st);
            n++;
        end while (st[15] && n < 30);
    endtask

    task automatic tgt_write(input logic [4:0] dev, input logic [4:0] rg, input logic [15:0] v);
        logic [15:0] d; int n;
        acc(1'b1, BR, 5'd1, v, d);
        acc(1'b1, BR, 5'd0, 16'h9400 | {6'd0, dev, rg}, d);
        poll(n, d);
    endtask

    task automatic tgt_read(input logic [4:0] dev, input logic [4:0] rg, output logic [15:0] v);
        logic [15:0] d; int n;
        acc(1'b1, BR, 5'd0, 16'h9800 | {6'd0, dev, rg}, d);
        poll(n, d);
        acc(1'b0, BR, 5'd1, 16'h0, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        do_reset();

        // R1 reset state
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R1 status after reset", rd, 16'h0000);
        acc(1'b0, BR, 5'd1, 16'h0, rd);
        chk("R1 data after reset", rd, 16'h0000);

        // R2 data register loopback
        acc(1'b1, BR, 5'd1, 16'hC3C3, rd);
        acc(1'b0, BR, 5'd1, 16'h0, rd);
        chk("R2 data loopback", rd, 16'hC3C3);

        // R4 then R3 over the table: all writes first, then all reads
        for (int i = 0; i < 6; i++)
            tgt_write(VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);
        for (int i = 0; i < 6; i++) begin
            tgt_read(VEC[i][25:21], VEC[i][20:16], rd);
            chk($sformatf("R3/R4 vector %0d", i), rd, VEC[i][15:0]);
        end

        // R10 command fields of last command (vector 5 read)
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R10 status fields", rd, {6'd0, 5'd30, 5'd17});

        // R5 busy window
        acc(1'b1, BR, 5'd0, 16'h9800 | {6'd0, 5'd1, 5'd2}, rd);
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R5 busy right after command", {15'd0, rd[15]}, 16'd1);
        poll(n, rd);
        chk("R5 busy clears in bound", {15'd0, (n <= ACK_LAT + 3) ? 1'b1 : 1'b0}, 16'd1);
        acc(1'b0, BR, 5'd1, 16'h0, rd);
        chk("R5 read result after busy", rd, 16'hA5A5);

        // R7 undefined opcode with bit 15 set
        acc(1'b1, BR, 5'd1, 16'h1111, rd);
        acc(1'b1, BR, 5'd0, 16'hDC00 | {6'd0, 5'd2, 5'd1}, rd);
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R7 undefined opcode status", rd, {6'd0, 5'd1, 5'd2});
        tgt_read(5'd2, 5'd1, rd);
        chk("R7 target untouched", rd, 16'h5A5A);

        // R6 command while busy
        acc(1'b1, BR, 5'd1, 16'h0F0F, rd);
        acc(1'b1, BR, 5'd0, 16'h9400 | {6'd0, 5'd3, 5'd3}, rd);
        acc(1'b1, BR, 5'd0, 16'h9400 | {6'd0, 5'd31, 5'd31}, rd);
        poll(n, rd);
        chk("R6 error flag set", {15'd0, rd[14]}, 16'd1);
        tgt_read(5'd31, 5'd31, rd);
        chk("R6 second command ignored", rd, 16'hFFFF);
        tgt_read(5'd3, 5'd3, rd);
        chk("R6 first command done", rd, 16'h0F0F);
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R6 error sticky", {15'd0, rd[14]}, 16'd1);

        // R9 other address ignored
        acc(1'b0, 5'd5, 5'd0, 16'h0, rd);
        chk("R9 foreign read", rd, 16'hFFFF);
        acc(1'b1, 5'd5, 5'd1, 16'hBEEF, rd);
        acc(1'b0, BR, 5'd1, 16'h0, rd);
        chk("R9 foreign write ignored", rd, 16'h0F0F);

        // R8 direct mode
        strap_addr = 5'd0;
        acc(1'b1, 5'd3, 5'd7, 16'h1357, rd);
        acc(1'b0, 5'd3, 5'd7, 16'h0, rd);
        chk("R8 direct read back", rd, 16'h1357);
        acc(1'b1, 5'd16, 5'd0, 16'h2468, rd);
        strap_addr = BR;
        tgt_read(5'd3, 5'd7, rd);
        chk("R8 direct write seen indirectly", rd, 16'h1357);
        tgt_read(5'd16, 5'd0, rd);
        chk("R8 direct bypasses bridge regs", rd, 16'h2468);

        // R1 reset clears error and data
        do_reset();
        acc(1'b0, BR, 5'd0, 16'h0, rd);
        chk("R1 error cleared by reset", rd, 16'h0000);
        acc(1'b0, BR, 5'd1, 16'h0, rd);
        chk("R1 data cleared by reset", rd, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule